// File: doc/BRIEF.md
# Cluster Memory Reply Distributor

This block sits on the network ejection port shared by a small group of processing cores. It takes memory reply packets off the network into a bounded first-in first-out store. Each cycle it offers the oldest stored packet to the one core port that owns it. A packet whose access type is instruction fetch goes to that core's fetch port. Every other packet goes to that core's load/store port. Each port is a valid/ready pair, and all ports share one payload bus.

The owning core is found from the packet's global core ID. The ID divided by the number of cores per cluster is the cluster number. The remainder is the local core index. A packet that is not a reply, or that names another cluster, sets a sticky error flag. Such a packet is still stored and delivered by its remainder.

For the request direction, the block has a purely combinational check of injection buffer space. A read is always charged the fixed read-packet size, whatever its load size. A write is charged its full size.

Top module: `clu_reply_router`

## Requirements
- R1: When the stored head packet has access type 3'd6 (instruction fetch), only `fetch_valid[c]` rises, where c is its local core index. Any other access type raises only `ls_valid[c]`. At most one valid bit of the two vectors is high in any cycle, and `out_data` carries the head payload. A packet accepted at a clock edge is offered from that edge on.
- R2: While the ready bit of the head packet's destination is low, the head stays offered with unchanged data, and the packets behind it wait. No other port valid is raised in that time.
- R3: `net_ready` is high exactly when the number of stored packets is below `EJ_LIMIT` (default 6), so the store never holds more than `EJ_LIMIT` packets.
- R4: A packet accepted with kind not equal to 2'd2 (reply) sets `err_flag`. So does a packet whose global ID divided by `CORES` is not `CLUSTER_ID` (default 1). The flag stays set until reset.
- R5: The local core index is the global ID modulo `CORES` (default 4). For example, IDs 4..7 address cores 0..3 of cluster 1, and ID 12 addresses core 0 of cluster 3.
- R6: A delivery to a core and an acceptance from the network may happen at the same clock edge. The occupancy test for `net_ready` uses the count held before that edge.
- R7: Packets are delivered in arrival order. With all destinations ready, one packet per cycle streams through with no bubble.
- R8: `inj_full` is high when the charged size exceeds `inj_room`. The charged size is `READ_PKT` (default 8) when `inj_write` is 0, and `inj_bytes` when it is 1.
- R9: After reset the store is empty, no port valid is high, `net_ready` is 1 and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| net_valid | input | 1 | Network offers a reply packet |
| net_ready | output | 1 | Block takes the offered packet at this edge |
| net_kind | input | 2 | Packet kind, 2'd2 = reply |
| net_acc | input | 3 | Access type, 3'd6 = instruction fetch |
| net_gid | input | GID_W (8) | Global core ID of the packet's owner |
| net_data | input | DW (16) | Packet payload |
| fetch_valid | output | CORES (4) | Per-core fetch port valid |
| fetch_ready | input | CORES (4) | Per-core fetch port has room |
| ls_valid | output | CORES (4) | Per-core load/store port valid |
| ls_ready | input | CORES (4) | Per-core load/store port has room |
| out_data | output | DW (16) | Payload of the offered packet |
| err_flag | output | 1 | Sticky malformed-packet flag |
| inj_write | input | 1 | Request to be injected is a write |
| inj_bytes | input | SZ_W (8) | Size of the request |
| inj_room | input | SZ_W (8) | Free space in the injection buffer |
| inj_full | output | 1 | Request does not fit |

## Verification
Delivery of the head to a core and acceptance of a new packet from the network can fall on the same clock edge. The bench fills the store to its limit with every core stalled while the network keeps offering a packet. It then opens the head's port. In that first cycle `net_ready` must still be low, because the count before the edge is at the limit. In the next cycle one pop and one push happen at the same edge. Correctness is judged by the count staying level (`net_ready` high again right after) and by the whole drained sequence arriving in arrival order, with the late packet last.

// File: rtl/clu_pkg.sv
// Shared encodings for the cluster reply distributor.
// Assumes the network marks replies with a two-bit kind and a three-bit access type.
package clu_pkg;
    typedef enum logic [1:0] {
        KIND_RD_REQ  = 2'd0,
        KIND_WR_REQ  = 2'd1,
        KIND_REPLY   = 2'd2,
        KIND_WR_ACK  = 2'd3
    } pkt_kind_e;

    typedef enum logic [2:0] {
        ACC_CONST_RD  = 3'd0,
        ACC_GLOB_RD   = 3'd1,
        ACC_GLOB_WR   = 3'd2,
        ACC_LOCAL_RD  = 3'd3,
        ACC_LOCAL_WR  = 3'd4,
        ACC_TEX_RD    = 3'd5,
        ACC_IFETCH_RD = 3'd6,
        ACC_RSVD      = 3'd7
    } acc_type_e;
endpackage

// File: rtl/clu_id_split.sv
// Splits a global core ID into cluster number and local core index.
// Assumes CORES >= 1; the divide and modulo are by a constant.
module clu_id_split #(
    parameter int GID_W = 8,
    parameter int CORES = 4,
    localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic [GID_W-1:0] gid,
    output logic [GID_W-1:0] cluster,
    output logic [IDX_W-1:0] local_idx
);
    localparam logic [GID_W-1:0] CORES_V = GID_W'(CORES);

    // Quotient and remainder of the global ID by the cluster size.
    always_comb begin
        cluster   = gid / CORES_V;
        local_idx = IDX_W'(gid % CORES_V);
    end
endmodule

// File: rtl/clu_reply_fifo.sv
// Ordered storage of reply entries, register based.
// Assumes the caller never pushes when full nor pops when empty.
module clu_reply_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             not_empty,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Write the incoming entry at the tail slot.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest entry.
    always_comb begin
        head      = mem[rd_ptr];
        not_empty = (count != '0);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH) || pop)) else $error("push into full store"); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty) else $error("pop from empty store"); // R2
endmodule

// File: rtl/clu_reply_steer.sv
// Decodes the head entry into one per-core valid and a pop strobe.
// Assumes head_idx < CORES, which holds since it is a remainder.
module clu_reply_steer #(
    parameter int CORES = 4,
    localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic             head_fetch,
    input  logic [IDX_W-1:0] head_idx,
    input  logic [CORES-1:0] fetch_ready,
    input  logic [CORES-1:0] ls_ready,
    output logic [CORES-1:0] fetch_valid,
    output logic [CORES-1:0] ls_valid,
    output logic             pop
);
    for (genvar c = 0; c < CORES; c++) begin : g_core
        logic mine;
        // Select this core's fetch or load/store port.
        always_comb begin
            mine           = head_valid && (head_idx == IDX_W'(c));
            fetch_valid[c] = mine && head_fetch;
            ls_valid[c]    = mine && !head_fetch;
        end
    end

    // Pop once the chosen destination has room.
    always_comb begin
        pop = |(fetch_valid & fetch_ready) || |(ls_valid & ls_ready);
    end

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_valid, ls_valid})) else $error("several ports offered"); // R1
endmodule

// File: rtl/clu_inject_check.sv
// Combinational injection-space test for an outgoing request.
// Assumes sizes and free room are in the same units.
module clu_inject_check #(
    parameter int SZ_W     = 8,
    parameter int READ_PKT = 8
) (
    input  logic            inj_write,
    input  logic [SZ_W-1:0] inj_bytes,
    input  logic [SZ_W-1:0] inj_room,
    output logic            inj_full
);
    localparam logic [SZ_W-1:0] RD_SZ = SZ_W'(READ_PKT);

    logic [SZ_W-1:0] need;

    // Reads are charged a fixed packet; writes their own size.
    always_comb begin
        need     = inj_write ? inj_bytes : RD_SZ;
        inj_full = need > inj_room;
    end
endmodule

// File: rtl/clu_reply_router.sv
// Top of the cluster reply distributor: admits network replies into an
// ordered store while below EJ_LIMIT, steers the head to its core's fetch or
// load/store port, flags malformed arrivals, and offers an injection check.
// Assumes EJ_LIMIT <= DEPTH and a network that holds its offer until taken.
module clu_reply_router
    import clu_pkg::*;
#(
    parameter int CORES      = 4,
    parameter int DEPTH      = 8,
    parameter int EJ_LIMIT   = 6,
    parameter int GID_W      = 8,
    parameter int DW         = 16,
    parameter int CLUSTER_ID = 1,
    parameter int SZ_W       = 8,
    parameter int READ_PKT   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             net_valid,
    output logic             net_ready,
    input  logic [1:0]       net_kind,
    input  logic [2:0]       net_acc,
    input  logic [GID_W-1:0] net_gid,
    input  logic [DW-1:0]    net_data,
    output logic [CORES-1:0] fetch_valid,
    input  logic [CORES-1:0] fetch_ready,
    output logic [CORES-1:0] ls_valid,
    input  logic [CORES-1:0] ls_ready,
    output logic [DW-1:0]    out_data,
    output logic             err_flag,
    input  logic             inj_write,
    input  logic [SZ_W-1:0]  inj_bytes,
    input  logic [SZ_W-1:0]  inj_room,
    output logic             inj_full
);
    localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1;
    localparam int ENT_W = 1 + IDX_W + DW;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(EJ_LIMIT);
    localparam logic [GID_W-1:0] MY_CLU  = GID_W'(CLUSTER_ID);

    logic [GID_W-1:0] in_cluster;
    logic [IDX_W-1:0] in_idx;
    logic             accept;
    logic             bad_pkt;
    logic [ENT_W-1:0] in_entry;
    logic [ENT_W-1:0] head;
    logic             head_valid;
    logic             head_fetch;
    logic [IDX_W-1:0] head_idx;
    logic             pop;
    logic [CNT_W-1:0] count;
    logic             err_q;

    clu_id_split #(.GID_W(GID_W), .CORES(CORES)) u_split (
        .gid       (net_gid),
        .cluster   (in_cluster),
        .local_idx (in_idx)
    );

    // Admission test on the pre-edge count, and entry packing.
    always_comb begin
        net_ready = count < LIMIT_V;
        accept    = net_valid && net_ready;
        bad_pkt   = (net_kind != KIND_REPLY) || (in_cluster != MY_CLU);
        in_entry  = {(net_acc == ACC_IFETCH_RD), in_idx, net_data};
    end

    clu_reply_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .din       (in_entry),
        .pop       (pop),
        .head      (head),
        .not_empty (head_valid),
        .count     (count)
    );

    // Unpack the head entry.
    always_comb begin
        head_fetch = head[ENT_W-1];
        head_idx   = head[DW +: IDX_W];
        out_data   = head[DW-1:0];
    end

    clu_reply_steer #(.CORES(CORES)) u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_valid  (head_valid),
        .head_fetch  (head_fetch),
        .head_idx    (head_idx),
        .fetch_ready (fetch_ready),
        .ls_ready    (ls_ready),
        .fetch_valid (fetch_valid),
        .ls_valid    (ls_valid),
        .pop         (pop)
    );

    // Sticky record of any malformed arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (accept && bad_pkt) err_q <= 1'b1;
    end
    assign err_flag = err_q;

    clu_inject_check #(.SZ_W(SZ_W), .READ_PKT(READ_PKT)) u_inj (
        .inj_write (inj_write),
        .inj_bytes (inj_bytes),
        .inj_room  (inj_room),
        .inj_full  (inj_full)
    );

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT_V) else $error("store above limit"); // R3
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop) |=> (head_valid && $stable(out_data))) else $error("head moved while stalled"); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q) else $error("error flag dropped"); // R4
endmodule

// File: tb/clu_reply_router_test.sv
`timescale 1ns/1ps
module clu_reply_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        net_valid = 1'b0;
    logic        net_ready;
    logic [1:0]  net_kind = 2'd2;
    logic [2:0]  net_acc = 3'd1;
    logic [7:0]  net_gid = 8'd4;
    logic [15:0] net_data = '0;
    logic [3:0]  fetch_valid, ls_valid;
    logic [3:0]  fetch_ready = 4'hF;
    logic [3:0]  ls_ready = 4'hF;
    logic [15:0] out_data;
    logic        err_flag;
    logic        inj_write = 1'b0;
    logic [7:0]  inj_bytes = '0;
    logic [7:0]  inj_room = '0;
    logic        inj_full;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    clu_reply_router uut (
        .clk(clk), .rst_n(rst_n),
        .net_valid(net_valid), .net_ready(net_ready), .net_kind(net_kind),
        .net_acc(net_acc), .net_gid(net_gid), .net_data(net_data),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .ls_valid(ls_valid), .ls_ready(ls_ready), .out_data(out_data),
        .err_flag(err_flag), .inj_write(inj_write), .inj_bytes(inj_bytes),
        .inj_room(inj_room), .inj_full(inj_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        net_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one packet, return at the negedge after it was taken.
    task automatic send(input logic [1:0] k, input logic [2:0] a,
                        input logic [7:0] g, input logic [15:0] d);
        @(negedge clk);
        net_kind = k; net_acc = a; net_gid = g; net_data = d;
        net_valid = 1'b1;
        while (!net_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        net_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 net_ready", {31'd0, net_ready}, 32'd1);
        chk("R9 fetch_valid", {28'd0, fetch_valid}, 32'd0);
        chk("R9 ls_valid", {28'd0, ls_valid}, 32'd0);
        chk("R9 err_flag", {31'd0, err_flag}, 32'd0);
    endtask

    task automatic t_route();
        fetch_ready = 4'hF; ls_ready = 4'hF;
        send(2'd2, 3'd6, 8'd6, 16'hA11C);
        chk("R1 fetch to core2", {28'd0, fetch_valid}, 32'h4);
        chk("R1 no ls", {28'd0, ls_valid}, 32'h0);
        chk("R1 data", {16'd0, out_data}, 32'hA11C);
        @(negedge clk);
        chk("R1 delivered", {28'd0, fetch_valid | ls_valid}, 32'h0);
        send(2'd2, 3'd1, 8'd7, 16'hB0B7);
        chk("R5 ls to core3", {28'd0, ls_valid}, 32'h8);
        chk("R1 no fetch", {28'd0, fetch_valid}, 32'h0);
        chk("R1 data ls", {16'd0, out_data}, 32'hB0B7);
        chk("R4 good packets leave flag", {31'd0, err_flag}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_block();
        fetch_ready = 4'hF; ls_ready = 4'h0;
        send(2'd2, 3'd3, 8'd4, 16'hAAAA);
        send(2'd2, 3'd6, 8'd5, 16'hBBBB);
        chk("R2 head held", {16'd0, out_data}, 32'hAAAA);
        chk("R2 ls core0 offered", {28'd0, ls_valid}, 32'h1);
        chk("R2 follower waits", {28'd0, fetch_valid}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R2 still held", {16'd0, out_data}, 32'hAAAA);
        chk("R2 still waits", {28'd0, fetch_valid}, 32'h0);
        ls_ready = 4'h1;
        @(negedge clk);
        chk("R7 next is follower", {16'd0, out_data}, 32'hBBBB);
        chk("R1 follower fetch core1", {28'd0, fetch_valid}, 32'h2);
        @(negedge clk);
        chk("R2 drained", {28'd0, fetch_valid | ls_valid}, 32'h0);
        ls_ready = 4'hF;
    endtask

    task automatic t_limit_and_overlap();
        fetch_ready = 4'h0; ls_ready = 4'h0;
        for (int k = 0; k < 6; k++)
            send(2'd2, 3'd1, 8'(4 + k % 4), 16'(16'h0100 + k));
        chk("R3 full at limit", {31'd0, net_ready}, 32'd0);
        net_kind = 2'd2; net_acc = 3'd1; net_gid = 8'd7; net_data = 16'h01FF;
        net_valid = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 refused at limit", {31'd0, net_ready}, 32'd0);
        ls_ready = 4'hF;
        chk("R6 pre-edge count used", {31'd0, net_ready}, 32'd0);
        @(negedge clk);
        chk("R6 room after pop", {31'd0, net_ready}, 32'd1);
        chk("R7 second in order", {16'd0, out_data}, 32'h0101);
        chk("R5 second to core1", {28'd0, ls_valid}, 32'h2);
        @(negedge clk);
        net_valid = 1'b0;
        chk("R6 push and pop same edge", {31'd0, net_ready}, 32'd1);
        for (int k = 2; k < 6; k++) begin
            chk("R7 drain order", {16'd0, out_data}, 32'h0100 + k);
            chk("R5 drain core", {28'd0, ls_valid}, 32'(1 << (k % 4)));
            @(negedge clk);
        end
        chk("R7 late packet last", {16'd0, out_data}, 32'h01FF);
        chk("R1 late to core3", {28'd0, ls_valid}, 32'h8);
        @(negedge clk);
        chk("R7 empty", {28'd0, fetch_valid | ls_valid}, 32'h0);
        fetch_ready = 4'hF;
    endtask

    task automatic t_stream();
        fetch_ready = 4'hF; ls_ready = 4'hF;
        @(negedge clk);
        net_kind = 2'd2; net_acc = 3'd6; net_gid = 8'd4; net_data = 16'h0200;
        net_valid = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R7 stream data", {16'd0, out_data}, 32'h0200 + k);
            chk("R7 stream core", {28'd0, fetch_valid}, 32'(1 << (k % 4)));
            chk("R7 stream ready", {31'd0, net_ready}, 32'd1);
            if (k < 4) begin
                net_gid = 8'(4 + (k + 1) % 4);
                net_data = 16'(16'h0200 + k + 1);
            end else begin
                net_valid = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    task automatic t_error();
        do_reset();
        fetch_ready = 4'hF; ls_ready = 4'hF;
        send(2'd2, 3'd1, 8'd12, 16'hE001);
        chk("R4 foreign cluster", {31'd0, err_flag}, 32'd1);
        chk("R5 id 12 to core0", {28'd0, ls_valid}, 32'h1);
        send(2'd2, 3'd1, 8'd5, 16'hE002);
        repeat (2) @(negedge clk);
        chk("R4 sticky", {31'd0, err_flag}, 32'd1);
        do_reset();
        chk("R9 flag cleared", {31'd0, err_flag}, 32'd0);
        send(2'd0, 3'd1, 8'd4, 16'hE003);
        chk("R4 wrong kind", {31'd0, err_flag}, 32'd1);
        @(negedge clk);
    endtask

    task automatic t_inject();
        inj_write = 1'b0; inj_bytes = 8'd40; inj_room = 8'd8;
        #1 chk("R8 read charged fixed", {31'd0, inj_full}, 32'd0);
        inj_room = 8'd7;
        #1 chk("R8 read no room", {31'd0, inj_full}, 32'd1);
        inj_write = 1'b1; inj_bytes = 8'd40; inj_room = 8'd8;
        #1 chk("R8 write full size", {31'd0, inj_full}, 32'd1);
        inj_bytes = 8'd8;
        #1 chk("R8 write fits", {31'd0, inj_full}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_route();
        t_block();
        t_limit_and_overlap();
        t_stream();
        t_error();
        t_inject();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule